// File: doc/BRIEF.md
# Programmable-Ratio Fourth-Order Sinc Decimator

This block turns the one-bit output of a delta-sigma modulator into 24-bit signed words. It is a fourth-order cascaded integrator-comb filter. Four integrators accumulate the bitstream at the modulator rate. Four comb (difference) stages run once per output word. The combined impulse response is four cascaded boxcars, each as long as the oversampling ratio (OSR). The result is a sinc-to-the-fourth response with exact zero-gain nulls at every multiple of the output word rate.

The OSR is picked at run time by a 4-bit code from eleven fixed ratios, two of which (12 and 24) are not powers of two. The modulator sample arrives with an enable that is normally high on every second clock, so the word rate is clk / (2 · OSR). A 32.768 MHz clock at OSR 12 therefore gives about 1365.33 k words per second.

An input-buffer flag adds a fixed delay of eight clocks to the data and strobe. The raw sum is rescaled to 24 bits with saturation. A flag marks the words produced before the filter has filled.

Top module: `sinc4_decim`

## Requirements
- R1: Code `osr_sel` selects the ratio: 0→12, 1→16, 2→24, 3→32, 4→64, 5→128, 6→256, 7→512, 8→1024, 9→2048, 10→4096.
- R2: Codes 11 to 15 behave exactly like ratio 32.
- R3: A sample is taken only on a clock where `mod_en` is high. Exactly one word is produced for every OSR samples taken.
- R4: `dvalid` is high for a single clock per word.
- R5: Each word equals the sum, over the samples taken since the last clear, of the four-fold boxcar convolution weights times the samples. Bit 1 counts as +1 and bit 0 as −1. The newest sample takes weight h[0] = 1. The sum is then scaled as in R6.
- R6: Let g be the smallest integer with 2^g ≥ OSR^4. The sum is shifted left by 23−g when g ≤ 23, or arithmetically right by g−23 otherwise. It is then saturated to [−8388608, 8388607]. All-ones input gives 8388607 at power-of-two ratios and 5308416 at ratios 12 and 24. All-zeros input gives −8388608.
- R7: With `buf_en` low, `dvalid` rises on the third rising edge after the edge that takes the word's last sample.
- R8: With `buf_en` high, that delay is eight clocks longer, so the rise falls on the eleventh edge.
- R9: A full-scale square wave whose period is exactly OSR samples decimates to exactly 0 once the filter is filled.
- R10: `settled` is low on the first four words after a clear and high on every later word.
- R11: Synchronous active-high `rst` clears all filter state and forces `dout`, `dvalid` and `settled` to 0. No word appears until OSR new samples have been taken.
- R12: A change of the decoded ratio on `osr_sel` clears all state as R11 does. A sample offered in that same clock is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | 1 | Modulator sample enable, normally every second clock |
| mod_bit | input | 1 | Modulator bit, 1 = +1, 0 = −1 |
| osr_sel | input | 4 | Decimation ratio code |
| buf_en | input | 1 | Input-buffer flag, adds eight clocks of latency |
| dout | output | 24 | Filtered word, two's complement |
| dvalid | output | 1 | One-clock strobe per word |
| settled | output | 1 | Word was produced after the filter filled |

## Verification
The bench sweeps every ratio code, including the unused ones, and compares each word with a directly summed impulse response. A wrong shift for the non-power-of-two ratios would give the wrong magnitude. A missing clip would turn the all-ones full-scale word into the most negative code. A square wave at the word rate targets the response nulls: any stage that slipped a sample would leave a nonzero residue.

The bench also checks the edge-exact latency with and without the buffer flag. It checks the position of the fifth word where `settled` first rises, so an off-by-one in the fill count is caught. It changes the ratio partway through a word and resets in mid-run. A design that kept stale integrator contents would then mismatch every following word.

// File: rtl/sinc4_pkg.sv
package sinc4_pkg;

    localparam int ORDER    = 4;
    localparam int OSR_MAXB = 12;
    localparam int ACC_W    = ORDER * OSR_MAXB + 2;
    localparam int OUT_W    = 24;
    localparam int SEL_W    = 4;
    localparam int OSR_W    = OSR_MAXB + 1;
    localparam int CNT_W    = OSR_MAXB;
    localparam int SH_W     = 6;
    localparam int BUF_DLY  = 8;
    localparam int SETTLE_N = ORDER;

    typedef logic [OSR_W-1:0]        osr_t;
    typedef logic [SH_W-1:0]         shamt_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef struct packed {
        logic   left;
        shamt_t amt;
    } shift_t;

    typedef struct packed {
        logic vld;
        logic stl;
        acc_t val;
    } raw_t;

    typedef struct packed {
        logic                    vld;
        logic                    stl;
        logic signed [OUT_W-1:0] data;
    } word_t;

    localparam osr_t OSR_FALLBACK = osr_t'(32);

    function automatic osr_t osr_decode(input logic [SEL_W-1:0] code);
        osr_t r;
        case (code)
            4'd0:    r = osr_t'(12);
            4'd1:    r = osr_t'(16);
            4'd2:    r = osr_t'(24);
            4'd3:    r = osr_t'(32);
            4'd4:    r = osr_t'(64);
            4'd5:    r = osr_t'(128);
            4'd6:    r = osr_t'(256);
            4'd7:    r = osr_t'(512);
            4'd8:    r = osr_t'(1024);
            4'd9:    r = osr_t'(2048);
            4'd10:   r = osr_t'(4096);
            default: r = OSR_FALLBACK;
        endcase
        return r;
    endfunction

    // Smallest g with 2**g >= osr**ORDER (ORDER fixed at 4 here).
    function automatic int gain_bits(input osr_t osr);
        logic [63:0] p;
        int          b;
        p = 64'(osr) * 64'(osr);
        p = p * p;
        b = 0;
        for (int k = 0; k < 63; k++) begin
            if ((64'd1 << k) < p) b = k + 1;
        end
        return b;
    endfunction

    function automatic shift_t shift_for(input osr_t osr);
        shift_t s;
        int     g;
        g = gain_bits(osr);
        if (g <= OUT_W - 1) begin
            s.left = 1'b1;
            s.amt  = shamt_t'(OUT_W - 1 - g);
        end else begin
            s.left = 1'b0;
            s.amt  = shamt_t'(g - (OUT_W - 1));
        end
        return s;
    endfunction

endpackage

// File: rtl/sinc4_ctrl.sv
module sinc4_ctrl
    import sinc4_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mod_en,
    input  logic [SEL_W-1:0] osr_sel,
    output logic             clr,
    output logic             take,
    output logic             wrap,
    output shift_t           shift
);

    osr_t             osr_cur;
    osr_t             osr_req;
    logic             chg;
    logic [CNT_W-1:0] cnt;

    assign osr_req = osr_decode(osr_sel);
    assign chg     = (osr_req != osr_cur);
    assign clr     = rst | chg;
    assign take    = mod_en & ~clr;
    assign wrap    = take & ({1'b0, cnt} == (osr_cur - osr_t'(1)));

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt     <= '0;
            osr_cur <= osr_req;
            shift   <= shift_for(osr_req);
        end else if (take) begin
            cnt <= wrap ? '0 : cnt + CNT_W'(1);
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, cnt} < osr_cur)); // R3

    AST_CNT_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!mod_en && !clr) |=> $stable(cnt)); // R3

    AST_RATIO_RESTART: assert property (@(posedge clk) disable iff (rst)
        chg |=> (cnt == '0)); // R12

endmodule

// File: rtl/sinc4_integ.sv
module sinc4_integ
    import sinc4_pkg::*;
#(
    parameter int N = ORDER
) (
    input  logic clk,
    input  logic clr,
    input  logic take,
    input  logic wrap,
    input  logic mod_bit,
    output logic samp_v,
    output acc_t samp_val
);

    acc_t acc [N];
    acc_t sum [N+1];

    assign sum[0] = mod_bit ? acc_t'(1) : acc_t'(-1);

    generate
        for (genvar g = 0; g < N; g++) begin : g_stage
            assign sum[g+1] = acc[g] + sum[g];
            always_ff @(posedge clk) begin
                if (clr)       acc[g] <= '0;
                else if (take) acc[g] <= sum[g+1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (clr) begin
            samp_v   <= 1'b0;
            samp_val <= '0;
        end else begin
            samp_v <= wrap;
            if (wrap) samp_val <= sum[N];
        end
    end

    AST_INTEG_IDLE: assert property (@(posedge clk) disable iff (clr)
        !take |=> ($stable(acc[0]) && $stable(acc[N-1]))); // R3

    AST_SAMPLE_NEEDS_TAKE: assert property (@(posedge clk) disable iff (clr)
        samp_v |-> $past(take)); // R3

endmodule

// File: rtl/sinc4_comb.sv
module sinc4_comb
    import sinc4_pkg::*;
#(
    parameter int N      = ORDER,
    parameter int SETTLE = SETTLE_N
) (
    input  logic clk,
    input  logic clr,
    input  logic in_v,
    input  acc_t in_val,
    output raw_t y
);

    localparam int SW = $clog2(SETTLE + 1);

    acc_t          dly [N];
    acc_t          dif [N+1];
    logic [SW-1:0] seen;

    assign dif[0] = in_val;

    generate
        for (genvar g = 0; g < N; g++) begin : g_stage
            assign dif[g+1] = dif[g] - dly[g];
            always_ff @(posedge clk) begin
                if (clr)       dly[g] <= '0;
                else if (in_v) dly[g] <= dif[g];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (clr) begin
            y    <= '0;
            seen <= '0;
        end else begin
            y.vld <= in_v;
            if (in_v) begin
                y.val <= dif[N];
                y.stl <= (seen == SW'(SETTLE));
                if (seen != SW'(SETTLE)) seen <= seen + SW'(1);
            end
        end
    end

    AST_FILL_MONOTONE: assert property (@(posedge clk) disable iff (clr)
        !clr |=> (seen >= $past(seen))); // R10

    AST_SETTLED_AFTER_FILL: assert property (@(posedge clk) disable iff (clr)
        (y.vld && y.stl) |-> (seen == SW'(SETTLE))); // R10

endmodule

// File: rtl/sinc4_scale.sv
module sinc4_scale
    import sinc4_pkg::*;
(
    input  logic   clk,
    input  logic   clr,
    input  raw_t   y,
    input  shift_t sh,
    output word_t  w
);

    localparam acc_t POS_LIM = (acc_t'(1) <<< (OUT_W - 1)) - acc_t'(1);
    localparam acc_t NEG_LIM = ~POS_LIM;

    acc_t                    val;
    acc_t                    shifted;
    logic signed [OUT_W-1:0] clipped;

    assign val     = y.val;
    assign shifted = sh.left ? (val <<< sh.amt) : (val >>> sh.amt);

    always_comb begin
        if (shifted > POS_LIM)      clipped = POS_LIM[OUT_W-1:0];
        else if (shifted < NEG_LIM) clipped = NEG_LIM[OUT_W-1:0];
        else                        clipped = shifted[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            w <= '0;
        end else begin
            w.vld <= y.vld;
            if (y.vld) begin
                w.stl  <= y.stl;
                w.data <= clipped;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (clr)
        (y.vld && sh.left) |-> ((shifted >>> sh.amt) == val)); // R6

endmodule

// File: rtl/sinc4_decim.sv
module sinc4_decim
    import sinc4_pkg::*;
#(
    parameter int DLY = BUF_DLY
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mod_en,
    input  logic             mod_bit,
    input  logic [SEL_W-1:0] osr_sel,
    input  logic             buf_en,
    output logic [OUT_W-1:0] dout,
    output logic             dvalid,
    output logic             settled
);

    logic   clr;
    logic   take;
    logic   wrap;
    shift_t shift;
    logic   samp_v;
    acc_t   samp_val;
    raw_t   comb_out;
    word_t  scaled;
    word_t  tap [1:DLY];
    word_t  sel;

    sinc4_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .mod_en  (mod_en),
        .osr_sel (osr_sel),
        .clr     (clr),
        .take    (take),
        .wrap    (wrap),
        .shift   (shift)
    );

    sinc4_integ #(.N(ORDER)) u_integ (
        .clk      (clk),
        .clr      (clr),
        .take     (take),
        .wrap     (wrap),
        .mod_bit  (mod_bit),
        .samp_v   (samp_v),
        .samp_val (samp_val)
    );

    sinc4_comb #(.N(ORDER), .SETTLE(SETTLE_N)) u_comb (
        .clk    (clk),
        .clr    (clr),
        .in_v   (samp_v),
        .in_val (samp_val),
        .y      (comb_out)
    );

    sinc4_scale u_scale (
        .clk (clk),
        .clr (clr),
        .y   (comb_out),
        .sh  (shift),
        .w   (scaled)
    );

    generate
        for (genvar g = 1; g <= DLY; g++) begin : g_buf
            if (g == 1) begin : g_head
                always_ff @(posedge clk) begin
                    if (clr) tap[g] <= '0;
                    else     tap[g] <= scaled;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (clr) tap[g] <= '0;
                    else     tap[g] <= tap[g-1];
                end
            end
        end
    endgenerate

    assign sel     = buf_en ? tap[DLY] : scaled;
    assign dout    = sel.data;
    assign dvalid  = sel.vld;
    assign settled = sel.stl;

    AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (rst)
        dvalid |=> !dvalid); // R4

endmodule

// File: tb/sim_sinc4_decim.sv
`timescale 1ns/1ps
module sim_sinc4_decim;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mod_en = 1'b0;
    logic        mod_bit = 1'b0;
    logic [3:0]  osr_sel = 4'd3;
    logic        buf_en = 1'b0;
    logic [23:0] dout;
    logic        dvalid;
    logic        settled;

    sinc4_decim u0 (
        .clk     (clk),
        .rst     (rst),
        .mod_en  (mod_en),
        .mod_bit (mod_bit),
        .osr_sel (osr_sel),
        .buf_en  (buf_en),
        .dout    (dout),
        .dvalid  (dvalid),
        .settled (settled)
    );

    always #10 clk = ~clk;

    int        checks = 0;
    int        errors = 0;
    int        hist [0:32767];
    longint    h    [0:16383];
    longint    tmp  [0:16383];
    int        hlen = 0;
    int        cur_osr = 32;
    int        nsamp = 0;
    int        nout = 0;
    int        got = 0;
    longint    exp_d [$];
    bit        exp_s [$];
    bit        lat_arm = 0;
    int        lat_cnt = 0;
    bit        prev_v = 0;
    int        pat = 0;
    bit        cur_buf = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int decode(input int code);
        case (code)
            0: return 12;    1: return 16;    2: return 24;   3: return 32;
            4: return 64;    5: return 128;   6: return 256;  7: return 512;
            8: return 1024;  9: return 2048;  10: return 4096;
            default: return 32;
        endcase
    endfunction

    function automatic longint scale_ref(input longint y, input int r);
        longint p;
        longint v;
        int     g;
        p = longint'(r) * r * r * r;
        g = 0;
        while ((longint'(1) << g) < p) g++;
        v = (g <= 23) ? (y <<< (23 - g)) : (y >>> (g - 23));
        if (v > 8388607)  v = 8388607;
        if (v < -8388608) v = -8388608;
        return v;
    endfunction

    task automatic build_h(input int r);
        int len;
        longint s;
        for (int i = 0; i < r; i++) h[i] = 1;
        len = r;
        repeat (3) begin
            s = 0;
            for (int n = 0; n < len + r - 1; n++) begin
                if (n < len) s += h[n];
                if (n >= r && n - r < len) s -= h[n - r];
                tmp[n] = s;
            end
            len = len + r - 1;
            for (int n = 0; n < len; n++) h[n] = tmp[n];
        end
        hlen = len;
    endtask

    task automatic get_bit(input int idx, output bit b);
        case (pat)
            0: b = 1'b1;
            1: b = 1'b0;
            3: b = ((idx % cur_osr) < cur_osr / 2);
            default: begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                b = lfsr[0];
            end
        endcase
    endtask

    task automatic push(input bit b);
        longint y;
        hist[nsamp] = b ? 1 : -1;
        nsamp++;
        if (nsamp % cur_osr == 0) begin
            y = 0;
            for (int j = 0; j < hlen && j < nsamp; j++) y += h[j] * hist[nsamp - 1 - j];
            exp_d.push_back(scale_ref(y, cur_osr));
            exp_s.push_back(nout >= 4);
            nout++;
            lat_arm = 1;
            lat_cnt = 0;
        end
    endtask

    task automatic monitor();
        longint ed;
        longint act;
        bit     es;
        if (lat_arm) lat_cnt++;
        if (dvalid) begin
            got++;
            chk(!prev_v, "R4 strobe longer than one clock", 1, 0);
            if (exp_d.size() == 0) begin
                chk(1'b0, "R3 unexpected word", 1, 0);
            end else begin
                ed  = exp_d.pop_front();
                es  = exp_s.pop_front();
                act = longint'($signed(dout));
                chk(act == ed, "R5 word value", act, ed);
                chk(settled == es, "R10 settled flag", settled, es);
                chk(lat_cnt == (cur_buf ? 11 : 3), cur_buf ? "R8 buffered latency" : "R7 latency",
                    lat_cnt, cur_buf ? 11 : 3);
                lat_arm = 0;
                if (pat == 3 && es) chk(act == 0, "R9 null at word rate", act, 0);
                if (pat == 0 && es && (cur_osr & (cur_osr - 1)) == 0)
                    chk(act == 8388607, "R6 positive full scale", act, 8388607);
                if (pat == 0 && es && (cur_osr == 12 || cur_osr == 24))
                    chk(act == 5308416, "R6 non power of two scale", act, 5308416);
                if (pat == 1 && es) chk(act == -8388608, "R6 negative full scale", act, -8388608);
            end
        end
        prev_v = dvalid;
    endtask

    task automatic step(input bit en, input bit b);
        @(negedge clk);
        monitor();
        mod_en  = en;
        mod_bit = b;
        if (en) push(b);
    endtask

    task automatic clear_ref(input int code);
        cur_osr = decode(code);
        build_h(cur_osr);
        nsamp   = 0;
        nout    = 0;
        got     = 0;
        lat_arm = 0;
        exp_d.delete();
        exp_s.delete();
    endtask

    task automatic do_reset(input int code, input bit be);
        @(negedge clk);
        monitor();
        rst     = 1'b1;
        mod_en  = 1'b0;
        osr_sel = 4'(code);
        buf_en  = be;
        cur_buf = be;
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        chk(dvalid == 0 && dout == 0 && settled == 0, "R11 outputs in reset",
            longint'({dvalid, settled, dout}), 0);
        @(negedge clk);
        monitor();
        rst = 1'b0;
        clear_ref(code);
    endtask

    task automatic feed(input int p, input int nw, input string tag);
        bit b;
        pat = p;
        for (int i = 0; i < nw * cur_osr; i++) begin
            get_bit(i, b);
            step(1'b1, b);
            step(1'b0, 1'b0);
        end
        repeat (16) step(1'b0, 1'b0);
        chk(exp_d.size() == 0 && got == nw, tag, got, nw);
    endtask

    task automatic partial(input int n);
        bit b;
        pat = 2;
        for (int i = 0; i < n; i++) begin
            get_bit(i, b);
            step(1'b1, b);
            step(1'b0, 1'b0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "WATCHDOG expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset(3, 1'b0);
        step(1'b0, 1'b0);
        chk(dvalid == 0 && dout == 0 && settled == 0, "R11 outputs after reset",
            longint'({dvalid, settled, dout}), 0);

        // R1: every defined ratio code against the summed impulse response
        for (int code = 0; code <= 10; code++) begin
            do_reset(code, 1'b0);
            feed(2, (decode(code) <= 512) ? 7 : 5, "R1 word count");
        end

        // R2: unused codes behave as ratio 32
        do_reset(11, 1'b0);
        feed(2, 6, "R2 word count");
        do_reset(15, 1'b0);
        feed(1, 6, "R2 word count");

        // R6: full-scale constant inputs
        do_reset(3, 1'b0);
        feed(0, 6, "R6 word count");
        do_reset(0, 1'b0);
        feed(0, 6, "R6 word count");
        do_reset(1, 1'b0);
        feed(0, 6, "R6 word count");
        do_reset(2, 1'b0);
        feed(0, 6, "R6 word count");
        do_reset(3, 1'b0);
        feed(1, 6, "R6 word count");

        // R9: square wave at the word rate
        do_reset(3, 1'b0);
        feed(3, 8, "R9 word count");
        do_reset(0, 1'b0);
        feed(3, 8, "R9 word count");

        // R8: buffered latency
        do_reset(0, 1'b1);
        feed(2, 6, "R8 word count");
        do_reset(5, 1'b1);
        feed(2, 6, "R8 word count");

        // R12: ratio change partway through a word
        do_reset(0, 1'b0);
        feed(2, 3, "R12 word count before change");
        partial(5);
        @(negedge clk);
        monitor();
        osr_sel = 4'd1;
        mod_en  = 1'b0;
        clear_ref(1);
        feed(2, 6, "R12 word count after change");

        // R11: reset in the middle of a word
        do_reset(3, 1'b0);
        partial(20);
        do_reset(3, 1'b0);
        feed(2, 6, "R11 word count after mid-run reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule